// File: doc/BRIEF.md
# Reshapeable Two-Clock Dual-Port RAM

This block is a 1,152-bit memory with one write port and one read port. Each port has its own clock. A 2-bit shape input decides at run time how the storage is seen: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. Both ports use a 9-bit address and an 18-bit data bus. A shape with fewer words decodes only the low address bits, and a narrower word uses only the low data lanes.

The storage is one flat bit vector. Word `k` of width `W` covers bits `k*W` up to `k*W+W-1`. Data written in one shape can therefore be read back in another shape, and the result is the same bits cut up differently.

The read port has two behaviours, chosen by a control input:
- **Combinational read:** the output follows the read address and the array contents directly.
- **Registered read:** the output is a register that loads on the read clock when read enable is high.

Top module: `ram_aspect_top`

## Requirements
- R1: While `rst` is high at a rising `rclk` edge, the read register clears to zero. With `async_rd` low, `rdata` is then 0.
- R2: The shape codes are fixed. `2'b00` gives 64 words x 18 bits. `2'b01` gives 128 x 9. `2'b10` gives 256 x 4. `2'b11` gives 512 x 2.
- R3: In a shape with N address bits, only `waddr[N-1:0]` and `raddr[N-1:0]` select the word. Higher address bits have no effect.
- R4: With `async_rd` high, `rdata` shows the addressed word as soon as `raddr` or `mode` changes, with no clock edge needed.
- R5: With `async_rd` low, a rising `rclk` edge with `ren` high loads the addressed word into `rdata`.
- R6: `rdata` bits at or above the word width W are always 0.
- R7: With `async_rd` low, a rising `rclk` edge with `ren` low leaves `rdata` unchanged.
- R8: With `async_rd` high, a write to the address being read shows up on `rdata` right after the `wclk` edge.
- R9: When one clock drives both ports, a registered read and a write to the same address on the same edge return the old data. The next enabled read returns the new data.
- R10: Logical bit i of word k lives at flat bit k*W+i. A write changes only those W bits, so `wdata` bits at or above W are ignored. Data written in one shape reads back in any other shape according to this mapping.
- R11: A rising `wclk` edge with `wen` low leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable, sampled on the `wclk` rising edge |
| waddr | input | 9 | Write word address |
| wdata | input | 18 | Write data; only the low W bits are stored |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset of the read register (in the `rclk` domain) |
| ren | input | 1 | Read enable for the registered read |
| raddr | input | 9 | Read word address |
| async_rd | input | 1 | 1 = combinational read, 0 = registered read |
| mode | input | 2 | Shape select (see R2) |
| rdata | output | 18 | Read data; bits at or above W are 0 |

## Verification
A write and a read can hit the same word in the same cycle. The bench ties both clocks to one source to force this.

- **Registered read:** it sets `wen` and `ren` with `waddr` equal to `raddr`. It expects the old word right after the shared edge and the new word one enabled edge later.
- **Combinational read:** it holds `raddr` on the word being written and expects the new value just after the write edge.

Whole-array write sweeps in each shape are read back in every shape. Each result is compared against a flat bit model updated by the k*W+i rule.

// File: rtl/ram_aspect_pkg.sv
package ram_aspect_pkg;

    localparam int TOTAL_BITS = 1152;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 18;
    localparam int IDX_W      = $clog2(TOTAL_BITS);
    localparam int WID_W      = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        SHAPE_64X18  = 2'b00,
        SHAPE_128X9  = 2'b01,
        SHAPE_256X4  = 2'b10,
        SHAPE_512X2  = 2'b11
    } shape_e;

    // Where one logical word sits inside the flat bit array
    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic [WID_W-1:0] width;
    } lane_t;

    function automatic logic [WID_W-1:0] shape_width(input shape_e s);
        case (s)
            SHAPE_64X18: return WID_W'(18);
            SHAPE_128X9: return WID_W'(9);
            SHAPE_256X4: return WID_W'(4);
            default:     return WID_W'(2);
        endcase
    endfunction

    function automatic int shape_abits(input shape_e s);
        case (s)
            SHAPE_64X18: return 6;
            SHAPE_128X9: return 7;
            SHAPE_256X4: return 8;
            default:     return 9;
        endcase
    endfunction

    function automatic lane_t lane_decode(input shape_e s, input logic [ADDR_W-1:0] a);
        lane_t            r;
        logic [ADDR_W-1:0] keep;
        logic [ADDR_W-1:0] word;
        keep    = (ADDR_W'(1) << shape_abits(s)) - ADDR_W'(1);
        word    = a & keep;
        r.width = shape_width(s);
        r.base  = IDX_W'(word) * IDX_W'(r.width);
        return r;
    endfunction

endpackage

// File: rtl/ram_aspect_decode.sv
module ram_aspect_decode
    import ram_aspect_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    output lane_t         lane
);
    always_comb begin
        lane = lane_decode(shape_e'(mode), ADDR_W'(addr));
    end
endmodule

// File: rtl/ram_aspect_array.sv
module ram_aspect_array
    import ram_aspect_pkg::*;
#(
    parameter int NBITS = TOTAL_BITS,
    parameter int DW    = DATA_W
) (
    input  logic             wclk,
    input  logic             wen,
    input  lane_t            wlane,
    input  logic [DW-1:0]    wdata,
    output logic [NBITS-1:0] bits_o
);
    logic [NBITS-1:0] cells;

    always_ff @(posedge wclk) begin
        if (wen) begin
            for (int i = 0; i < DW; i++) begin
                if (WID_W'(i) < wlane.width) begin
                    cells[wlane.base + IDX_W'(i)] <= wdata[i];
                end
            end
        end
    end

    assign bits_o = cells;
endmodule

// File: rtl/ram_aspect_extract.sv
module ram_aspect_extract
    import ram_aspect_pkg::*;
#(
    parameter int NBITS = TOTAL_BITS,
    parameter int DW    = DATA_W
) (
    input  logic [NBITS-1:0] bits_i,
    input  lane_t            rlane,
    output logic [DW-1:0]    lane_data
);
    always_comb begin
        lane_data = '0;
        for (int i = 0; i < DW; i++) begin
            if (WID_W'(i) < rlane.width) begin
                lane_data[i] = bits_i[rlane.base + IDX_W'(i)];
            end
        end
    end
endmodule

// File: rtl/ram_aspect_rdout.sv
module ram_aspect_rdout
    import ram_aspect_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren,
    input  logic          async_rd,
    input  logic [DW-1:0] lane_data,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] held;

    always_ff @(posedge rclk) begin
        if (rst) begin
            held <= '0;
        end else if (ren) begin
            held <= lane_data;
        end
    end

    assign rdata = async_rd ? lane_data : held;
endmodule

// File: rtl/ram_aspect_top.sv
module ram_aspect_top
    import ram_aspect_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int NBITS = TOTAL_BITS
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    input  logic          async_rd,
    input  logic [1:0]    mode,
    output logic [DW-1:0] rdata
);
    lane_t            wr_lane;
    lane_t            rd_lane_pos;
    logic [NBITS-1:0] flat_bits;
    logic [DW-1:0]    rd_lane;

    ram_aspect_decode #(.AW(AW)) u_wdec (
        .mode (mode),
        .addr (waddr),
        .lane (wr_lane)
    );

    ram_aspect_decode #(.AW(AW)) u_rdec (
        .mode (mode),
        .addr (raddr),
        .lane (rd_lane_pos)
    );

    ram_aspect_array #(.NBITS(NBITS), .DW(DW)) u_array (
        .wclk   (wclk),
        .wen    (wen),
        .wlane  (wr_lane),
        .wdata  (wdata),
        .bits_o (flat_bits)
    );

    ram_aspect_extract #(.NBITS(NBITS), .DW(DW)) u_extract (
        .bits_i    (flat_bits),
        .rlane     (rd_lane_pos),
        .lane_data (rd_lane)
    );

    ram_aspect_rdout #(.DW(DW)) u_rdout (
        .rclk      (rclk),
        .rst       (rst),
        .ren       (ren),
        .async_rd  (async_rd),
        .lane_data (rd_lane),
        .rdata     (rdata)
    );
endmodule

// File: rtl/ram_aspect_checker.sv
module ram_aspect_checker #(
    parameter int DW = 18
) (
    input logic          rclk,
    input logic          rst,
    input logic          ren,
    input logic          async_rd,
    input logic [1:0]    mode,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] lane_data
);
    // R5: an enabled registered read presents the word decoded before the edge
    p_capture_r5: assert property (@(posedge rclk) disable iff (rst)
        (ren && !async_rd) |=> (async_rd || rdata == $past(lane_data)));

    // R7: registered output does not move when the previous edge had ren low
    p_hold_r7: assert property (@(posedge rclk) disable iff (rst)
        (!async_rd && !$past(async_rd) && !$past(ren)) |-> $stable(rdata));

    // R6: unused upper lanes are zero in the narrow shapes
    p_upper_zero_2b_r6: assert property (@(posedge rclk) disable iff (rst)
        (async_rd && mode == 2'b11) |-> (rdata[DW-1:2] == '0));

    p_upper_zero_4b_r6: assert property (@(posedge rclk) disable iff (rst)
        (async_rd && mode == 2'b10) |-> (rdata[DW-1:4] == '0));

    p_upper_zero_9b_r6: assert property (@(posedge rclk) disable iff (rst)
        (async_rd && mode == 2'b01) |-> (rdata[DW-1:9] == '0));
endmodule

bind ram_aspect_top ram_aspect_checker #(.DW(DW)) u_chk (
    .rclk      (rclk),
    .rst       (rst),
    .ren       (ren),
    .async_rd  (async_rd),
    .mode      (mode),
    .rdata     (rdata),
    .lane_data (rd_lane)
);

// File: tb/ram_aspect_top_bench.sv
module ram_aspect_top_bench;
    logic        clk = 1'b0;
    logic        rst, wen, ren, async_rd;
    logic [8:0]  waddr, raddr;
    logic [17:0] wdata;
    logic [1:0]  mode;
    logic [17:0] rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [1151:0] model;

    always #10 clk = ~clk;

    ram_aspect_top u_ram_aspect_top (
        .wclk(clk), .wen(wen), .waddr(waddr), .wdata(wdata),
        .rclk(clk), .rst(rst), .ren(ren), .raddr(raddr),
        .async_rd(async_rd), .mode(mode), .rdata(rdata)
    );

    function automatic int wid(input logic [1:0] m);
        return (m == 2'd0) ? 18 : (m == 2'd1) ? 9 : (m == 2'd2) ? 4 : 2;
    endfunction

    function automatic logic [17:0] model_read(input logic [1:0] m, input logic [8:0] a);
        logic [17:0] r = '0;
        int w    = wid(m);
        int base = (int'(a) % (1 << (6 + int'(m)))) * w;
        for (int i = 0; i < w; i++) r[i] = model[base + i];
        return r;
    endfunction

    task automatic model_write(input logic [1:0] m, input logic [8:0] a, input logic [17:0] d);
        int w    = wid(m);
        int base = (int'(a) % (1 << (6 + int'(m)))) * w;
        for (int i = 0; i < w; i++) model[base + i] = d[i];
    endtask

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input logic [8:0] a, input logic [17:0] d);
        @(negedge clk);
        mode = m; waddr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        model_write(m, a, d);
    endtask

    task automatic async_check(input string req, input logic [1:0] m, input logic [8:0] a);
        @(negedge clk);
        async_rd = 1'b1; mode = m; raddr = a;
        #2;
        check(req, rdata, model_read(m, a));
    endtask

    function automatic logic [17:0] pat(input int m, input int k, input int seed);
        return 18'((k * 2654435 + seed * 977 + m * 31 + 12345) ^ (k << 7));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wen = 1'b0; ren = 1'b0; async_rd = 1'b0;
        waddr = '0; raddr = '0; wdata = '0; mode = 2'b00;
        repeat (4) @(posedge clk);
        #2;
        check("R1 reset clears read register", rdata, 18'h0);
        @(negedge clk); rst = 1'b0;

        // Fill every shape's full depth, then read back in all four shapes (R2, R10, R6, R3)
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < (64 << m); k++)
                do_write(2'(m), 9'(k), pat(m, k, 1));
            for (int m2 = 0; m2 < 4; m2++)
                for (int k = 0; k < (64 << m2); k++)
                    async_check("R2/R10 cross-shape mapping", 2'(m2),
                                9'(k | (k << (6 + m2))));
        end

        // R3: high write-address bits ignored
        do_write(2'b00, 9'h1C5, 18'h2A5A5);
        async_check("R3 write high bits ignored", 2'b00, 9'h005);
        check("R3 aliased value", rdata, 18'h2A5A5);

        // R4: combinational follow without clock
        @(negedge clk); async_rd = 1'b1; mode = 2'b01;
        raddr = 9'd3;  #1 check("R4 async follow a", rdata, model_read(2'b01, 9'd3));
        raddr = 9'd77; #1 check("R4 async follow b", rdata, model_read(2'b01, 9'd77));
        mode  = 2'b11; #1 check("R4 async mode change", rdata, model_read(2'b11, 9'd77));

        // R5: registered sweep in every shape
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < (64 << m); k += 3) begin
                @(negedge clk);
                async_rd = 1'b0; ren = 1'b1; mode = 2'(m); raddr = 9'(k);
                @(posedge clk); #2;
                check("R5 registered read", rdata, model_read(2'(m), 9'(k)));
            end
        end

        // R7: hold with ren low
        @(negedge clk); mode = 2'b00; raddr = 9'd10; ren = 1'b1;
        @(posedge clk); #2;
        check("R5 load before hold", rdata, model_read(2'b00, 9'd10));
        @(negedge clk); ren = 1'b0; raddr = 9'd11;
        @(posedge clk); #2;
        check("R7 hold when ren low", rdata, model_read(2'b00, 9'd10));

        // R9: same edge write and registered read returns old data
        @(negedge clk);
        begin
            logic [17:0] old_v;
            old_v = model_read(2'b00, 9'd5);
            mode = 2'b00; async_rd = 1'b0; ren = 1'b1; raddr = 9'd5;
            wen = 1'b1; waddr = 9'd5; wdata = ~old_v;
            @(posedge clk); #2;
            check("R9 same edge old data", rdata, old_v);
            model_write(2'b00, 9'd5, ~old_v);
            @(negedge clk); wen = 1'b0;
            @(posedge clk); #2;
            check("R9 next read new data", rdata, ~old_v);
        end

        // R8: write-through in combinational mode
        @(negedge clk);
        async_rd = 1'b1; ren = 1'b0; mode = 2'b10; raddr = 9'd9;
        wen = 1'b1; waddr = 9'd9; wdata = 18'h3FFF6;
        @(posedge clk); #2;
        model_write(2'b10, 9'd9, 18'h3FFF6);
        check("R8 write visible after wclk", rdata, 18'h00006);
        @(negedge clk); wen = 1'b0;

        // R10: a 2-bit write touches only two bits of an 18-bit word
        do_write(2'b00, 9'd20, 18'h00000);
        do_write(2'b11, 9'd185, 18'h3FFFF);
        async_check("R10 narrow write confined", 2'b00, 9'd20);
        check("R10 exact bits", rdata, 18'h00C00);

        // R11: wen low does not write
        @(negedge clk); mode = 2'b00; waddr = 9'd20; wdata = 18'h15555; wen = 1'b0;
        @(posedge clk);
        async_check("R11 disabled write ignored", 2'b00, 9'd20);
        check("R11 exact value", rdata, 18'h00C00);

        // R6: upper lanes zero in a 9-bit read
        async_check("R6 upper lanes", 2'b01, 9'd40);
        check("R6 bits above 9 zero", rdata & 18'h3FE00, 18'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule